// File: doc/BRIEF.md
# Program-Counter-Qualified Region Access Checker

This block sits next to a CPU and a system interconnect and rules on every data access before it reaches protected storage or protected peripheral control space. Code counts as trusted when the program counter of the access lies inside one of two enabled secure code windows: one for flash and one for SRAM. No privilege signal is involved. The target address is compared against four protected data regions: a flash data region (index 0), an SRAM data region (index 1) and two peripheral-control regions (indices 2 and 3).

Each requester class is checked against its own set of regions:

- Instruction fetches are never checked, so untrusted code can still execute trusted routines.
- CPU data-bus traffic is checked against regions 0 and 1, unless the code is trusted.
- The system/debug bus is checked against regions 1, 2 and 3, whatever the program counter holds.
- The three bus-master groups are checked against all four regions.

The whole configuration is captured while reset is held. It is frozen from the first clock after reset release, so it governs the very first fetch.

The verdict is registered. It appears on the clock edge after the request is presented, which is also the cycle in which the memory returns read data. At that point a denied read is masked to zero, a denied write has its write strobe withheld, and a violation pulse is raised.

Top module: `secmpu_gate`

## Requirements
- R1: A CPU data-bus access (source 0) whose program counter lies inclusively between the start and end of an enabled secure code window is granted, whatever its address.
- R2: Region and window matching compares full 32-bit values inclusively at both ends. A disabled region or window never matches.
- R3: For an untrusted CPU data-bus access, only regions 0 and 1 are checked. An address that falls only in region 2 or 3 is granted.
- R4: An access of kind fetch (code 0), or any access from the CPU instruction bus (source 1), is always granted.
- R5: A system/debug bus access (source 2) is denied when it hits region 1, 2 or 3, and granted when it hits only region 0. The program counter has no effect on it.
- R6: A bus-master-group access (sources 3, 4, 5; codes 6 and 7 are treated the same way) is denied when it hits any of the four regions.
- R7: Region 2 or 3 takes effect only if it is enabled and lies wholly inside 0x400C0000..0x400DFFFF or wholly inside 0x40100000..0x407FFFFF. Otherwise it behaves as disabled.
- R8: The configuration inputs are sampled on every clock while reset is low. They are ignored from reset release until the next reset.
- R9: One cycle after a valid request, exactly one of grant_o and viol_o is high. For a granted read (kind 1, or 3 which counts as read), rd_data_o passes rd_data_i. For a denied read, rd_data_o is zero.
- R10: One cycle after a granted write (kind 2), wr_en_o is high. After a denied write it stays low.
- R11: In reset, and in the cycle after a cycle with no valid request, grant_o, viol_o and wr_en_o are low and rd_data_o is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; configuration is captured while low |
| cfg_pc_start_i | input | 64 | Secure code window starts, window k in bits [32k+31:32k] (0 flash, 1 SRAM) |
| cfg_pc_end_i | input | 64 | Secure code window ends (inclusive) |
| cfg_pc_en_i | input | 2 | Secure code window enables |
| cfg_rg_start_i | input | 128 | Protected region starts, region k in bits [32k+31:32k] |
| cfg_rg_end_i | input | 128 | Protected region ends (inclusive) |
| cfg_rg_en_i | input | 4 | Protected region enables |
| req_valid_i | input | 1 | Access request present this cycle |
| req_pc_i | input | 32 | Program counter of the requesting code |
| req_addr_i | input | 32 | Access address |
| req_kind_i | input | 2 | 0 fetch, 1 read, 2 write, 3 read |
| req_src_i | input | 3 | 0 CPU data bus, 1 CPU instruction bus, 2 system/debug bus, 3..5 bus-master groups |
| rd_data_i | input | 32 | Read data from memory, one cycle after the request |
| grant_o | output | 1 | Access allowed (registered) |
| viol_o | output | 1 | Access denied, one pulse per denied request |
| wr_en_o | output | 1 | Write strobe forwarded to memory for granted writes |
| rd_data_o | output | 32 | Read data returned to the requester, zero unless a granted read |

## Verification
On every cycle, the assertions check:

- that fetches and instruction-bus traffic are never refused;
- that grant and violation never coincide;
- that a violation never leaks read data;
- that the write strobe never appears without a grant;
- that an idle cycle leaves the outputs quiet;
- that the latched configuration does not move after reset.

Several behaviours can only be shown by the bench's scenarios, which compare each verdict against the expected rule:

- which regions each bus source is checked against;
- the inclusive edges of regions and secure code windows;
- the loss of effect of a peripheral-control region that strays outside its permitted span;
- the fact that changes to the configuration inputs after reset take no effect until the next reset.

// File: rtl/secmpu_pkg.sv
// Package: shared encodings and constants for the region access checker.
// Assumes 32-bit addresses; the permitted peripheral-control spans are fixed.
package secmpu_pkg;
    localparam int ADDR_W  = 32;
    localparam int DATA_W  = 32;
    localparam int N_PCWIN = 2;
    localparam int N_RGN   = 4;
    localparam int FN_BASE = 2;   // first peripheral-control region index

    typedef enum logic [1:0] {
        KIND_FETCH = 2'd0,
        KIND_READ  = 2'd1,
        KIND_WRITE = 2'd2,
        KIND_READX = 2'd3
    } acc_kind_e;

    localparam logic [2:0] SRC_CPU_D = 3'd0;
    localparam logic [2:0] SRC_CPU_I = 3'd1;
    localparam logic [2:0] SRC_SYS   = 3'd2;

    localparam logic [ADDR_W-1:0] CRYPTO_LO = 32'h400C_0000;
    localparam logic [ADDR_W-1:0] CRYPTO_HI = 32'h400D_FFFF;
    localparam logic [ADDR_W-1:0] FLCTL_LO  = 32'h4010_0000;
    localparam logic [ADDR_W-1:0] FLCTL_HI  = 32'h407F_FFFF;

    // Region coverage per bus source (bit k = region k is checked).
    function automatic logic [N_RGN-1:0] src_cover(input logic [2:0] src);
        case (src)
            SRC_CPU_D: src_cover = 4'b0011;
            SRC_CPU_I: src_cover = 4'b0000;
            SRC_SYS:   src_cover = 4'b1110;
            default:   src_cover = 4'b1111;
        endcase
    endfunction

    // True when [lo,hi] lies wholly inside one permitted control span.
    function automatic logic in_fn_span(input logic [ADDR_W-1:0] lo,
                                        input logic [ADDR_W-1:0] hi);
        in_fn_span = (lo <= hi) &&
                     (((lo >= CRYPTO_LO) && (hi <= CRYPTO_HI)) ||
                      ((lo >= FLCTL_LO)  && (hi <= FLCTL_HI)));
    endfunction
endpackage

// File: rtl/secmpu_cfg_latch.sv
// Configuration capture: samples the region and window settings on every
// clock while reset is low and holds them afterwards. Peripheral-control
// regions whose bounds leave the permitted spans are stored as disabled.
// Assumes the configuration inputs are stable during the last reset cycle.
module secmpu_cfg_latch #(
    parameter int AW    = secmpu_pkg::ADDR_W,
    parameter int NPC   = secmpu_pkg::N_PCWIN,
    parameter int NRG   = secmpu_pkg::N_RGN,
    parameter int FNIDX = secmpu_pkg::FN_BASE
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPC*AW-1:0] pc_start_i,
    input  logic [NPC*AW-1:0] pc_end_i,
    input  logic [NPC-1:0]    pc_en_i,
    input  logic [NRG*AW-1:0] rg_start_i,
    input  logic [NRG*AW-1:0] rg_end_i,
    input  logic [NRG-1:0]    rg_en_i,
    output logic [NPC*AW-1:0] pc_start_o,
    output logic [NPC*AW-1:0] pc_end_o,
    output logic [NPC-1:0]    pc_en_o,
    output logic [NRG*AW-1:0] rg_start_o,
    output logic [NRG*AW-1:0] rg_end_o,
    output logic [NRG-1:0]    rg_en_o
);
    logic [NRG-1:0] rg_en_ok;

    // Qualify each region enable; control regions must respect their span.
    for (genvar g = 0; g < NRG; g++) begin : g_qual
        if (g >= FNIDX) begin : g_fn
            assign rg_en_ok[g] = rg_en_i[g] &&
                secmpu_pkg::in_fn_span(rg_start_i[g*AW +: AW], rg_end_i[g*AW +: AW]);
        end else begin : g_mem
            assign rg_en_ok[g] = rg_en_i[g];
        end
    end

    // Capture while in reset, hold once released.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_start_o <= pc_start_i;
            pc_end_o   <= pc_end_i;
            pc_en_o    <= pc_en_i;
            rg_start_o <= rg_start_i;
            rg_end_o   <= rg_end_i;
            rg_en_o    <= rg_en_ok;
        end
    end

    // R8
    cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ($stable(rg_en_o) && $stable(pc_en_o) &&
                          $stable(rg_start_o) && $stable(rg_end_o) &&
                          $stable(pc_start_o) && $stable(pc_end_o)));
    // R7
    fn_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rg_en_o[FNIDX] |-> secmpu_pkg::in_fn_span(rg_start_o[FNIDX*AW +: AW],
                                                  rg_end_o[FNIDX*AW +: AW])));
endmodule

// File: rtl/secmpu_range_match.sv
// Inclusive range matcher: one comparator pair per entry, gated by enable.
// Assumes start/end are unsigned; an empty range (start > end) never hits.
module secmpu_range_match #(
    parameter int AW = secmpu_pkg::ADDR_W,
    parameter int N  = 4
) (
    input  logic [N*AW-1:0] start_i,
    input  logic [N*AW-1:0] end_i,
    input  logic [N-1:0]    en_i,
    input  logic [AW-1:0]   probe_i,
    output logic [N-1:0]    hit_o
);
    // One comparator pair per entry.
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hit_o[g] = en_i[g] &&
                          (probe_i >= start_i[g*AW +: AW]) &&
                          (probe_i <= end_i[g*AW +: AW]);
    end
endmodule

// File: rtl/secmpu_gate.sv
// Region access checker top: classifies the requester as trusted from its
// program counter, matches the address against the protected regions that
// its bus source is subject to, and registers a grant/violation verdict.
// Assumes read data arrives one cycle after the request, aligned with the
// registered verdict, and that writes are committed from wr_en_o.
module secmpu_gate #(
    parameter int AW  = secmpu_pkg::ADDR_W,
    parameter int DW  = secmpu_pkg::DATA_W,
    parameter int NPC = secmpu_pkg::N_PCWIN,
    parameter int NRG = secmpu_pkg::N_RGN
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPC*AW-1:0] cfg_pc_start_i,
    input  logic [NPC*AW-1:0] cfg_pc_end_i,
    input  logic [NPC-1:0]    cfg_pc_en_i,
    input  logic [NRG*AW-1:0] cfg_rg_start_i,
    input  logic [NRG*AW-1:0] cfg_rg_end_i,
    input  logic [NRG-1:0]    cfg_rg_en_i,
    input  logic              req_valid_i,
    input  logic [AW-1:0]     req_pc_i,
    input  logic [AW-1:0]     req_addr_i,
    input  logic [1:0]        req_kind_i,
    input  logic [2:0]        req_src_i,
    input  logic [DW-1:0]     rd_data_i,
    output logic              grant_o,
    output logic              viol_o,
    output logic              wr_en_o,
    output logic [DW-1:0]     rd_data_o
);
    import secmpu_pkg::*;

    logic [NPC*AW-1:0] pc_start_q, pc_end_q;
    logic [NPC-1:0]    pc_en_q;
    logic [NRG*AW-1:0] rg_start_q, rg_end_q;
    logic [NRG-1:0]    rg_en_q;
    logic [NPC-1:0]    pc_hit;
    logic [NRG-1:0]    rg_hit;
    logic              trusted, bypass, allow, is_wr, is_rd;
    logic              rd_pass_q;

    secmpu_cfg_latch #(.AW(AW), .NPC(NPC), .NRG(NRG), .FNIDX(FN_BASE)) i_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .pc_start_i (cfg_pc_start_i),
        .pc_end_i   (cfg_pc_end_i),
        .pc_en_i    (cfg_pc_en_i),
        .rg_start_i (cfg_rg_start_i),
        .rg_end_i   (cfg_rg_end_i),
        .rg_en_i    (cfg_rg_en_i),
        .pc_start_o (pc_start_q),
        .pc_end_o   (pc_end_q),
        .pc_en_o    (pc_en_q),
        .rg_start_o (rg_start_q),
        .rg_end_o   (rg_end_q),
        .rg_en_o    (rg_en_q)
    );

    secmpu_range_match #(.AW(AW), .N(NPC)) i_pcwin (
        .start_i (pc_start_q),
        .end_i   (pc_end_q),
        .en_i    (pc_en_q),
        .probe_i (req_pc_i),
        .hit_o   (pc_hit)
    );

    secmpu_range_match #(.AW(AW), .N(NRG)) i_rgn (
        .start_i (rg_start_q),
        .end_i   (rg_end_q),
        .en_i    (rg_en_q),
        .probe_i (req_addr_i),
        .hit_o   (rg_hit)
    );

    // Verdict: fetches and instruction bus pass, trusted CPU data passes,
    // otherwise any hit on a region covered for this source is refused.
    always_comb begin
        trusted = (req_src_i == SRC_CPU_D) && (|pc_hit);
        bypass  = (req_kind_i == KIND_FETCH) || (req_src_i == SRC_CPU_I);
        allow   = bypass || trusted || ~|(rg_hit & src_cover(req_src_i));
        is_wr   = (req_kind_i == KIND_WRITE);
        is_rd   = (req_kind_i == KIND_READ) || (req_kind_i == KIND_READX);
    end

    // Register the verdict and the write/read release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant_o   <= 1'b0;
            viol_o    <= 1'b0;
            wr_en_o   <= 1'b0;
            rd_pass_q <= 1'b0;
        end else begin
            grant_o   <= req_valid_i && allow;
            viol_o    <= req_valid_i && !allow;
            wr_en_o   <= req_valid_i && allow && is_wr;
            rd_pass_q <= req_valid_i && allow && is_rd;
        end
    end

    // Return data only for a granted read.
    assign rd_data_o = rd_pass_q ? rd_data_i : '0;

    // R4
    fetch_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && (req_kind_i == KIND_FETCH || req_src_i == SRC_CPU_I)) |=> grant_o);
    // R9
    verdict_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(grant_o && viol_o));
    // R9
    denied_rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        viol_o |-> (rd_data_o == '0));
    // R10
    wr_needs_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> grant_o);
    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid_i |=> (!grant_o && !viol_o && !wr_en_o));
    // R1
    trusted_cpu_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_src_i == SRC_CPU_D && (|pc_hit)) |=> grant_o);
endmodule

// File: tb/test_secmpu_gate.sv
// Bench: vector table walked by one loop, then directed reset/config tests.
module test_secmpu_gate;
    localparam int AW = 32;
    localparam int DW = 32;
    localparam logic [DW-1:0] MEMPAT = 32'hA5A5_5A5A;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [2*AW-1:0] cfg_pc_start, cfg_pc_end;
    logic [1:0]      cfg_pc_en;
    logic [4*AW-1:0] cfg_rg_start, cfg_rg_end;
    logic [3:0]      cfg_rg_en;
    logic            req_valid = 1'b0;
    logic [AW-1:0]   req_pc = '0, req_addr = '0;
    logic [1:0]      req_kind = '0;
    logic [2:0]      req_src = '0;
    logic [DW-1:0]   rd_data_in = MEMPAT;
    logic            grant, viol, wr_en;
    logic [DW-1:0]   rd_data_out;
    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;   // 250 MHz

    secmpu_gate i_secmpu_gate (
        .clk(clk), .rst_n(rst_n),
        .cfg_pc_start_i(cfg_pc_start), .cfg_pc_end_i(cfg_pc_end), .cfg_pc_en_i(cfg_pc_en),
        .cfg_rg_start_i(cfg_rg_start), .cfg_rg_end_i(cfg_rg_end), .cfg_rg_en_i(cfg_rg_en),
        .req_valid_i(req_valid), .req_pc_i(req_pc), .req_addr_i(req_addr),
        .req_kind_i(req_kind), .req_src_i(req_src), .rd_data_i(rd_data_in),
        .grant_o(grant), .viol_o(viol), .wr_en_o(wr_en), .rd_data_o(rd_data_out)
    );

    typedef struct packed {
        logic [31:0] pc;
        logic [31:0] addr;
        logic [1:0]  kind;
        logic [2:0]  src;
        logic        exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VEC [NV] = '{
        '{32'h0000_8000, 32'h0000_2000, 2'd1, 3'd0, 1'b0, 8'd3},  // R3 untrusted cpu hits r0
        '{32'h0000_1800, 32'h0000_2000, 2'd1, 3'd0, 1'b1, 8'd1},  // R1 trusted flash code
        '{32'h0000_8000, 32'h0000_2000, 2'd0, 3'd1, 1'b1, 8'd4},  // R4 fetch
        '{32'h0000_8000, 32'h0000_5000, 2'd1, 3'd0, 1'b1, 8'd2},  // R2 outside regions
        '{32'h0000_8000, 32'h400C_0010, 2'd1, 3'd0, 1'b1, 8'd3},  // R3 cpu skips r2
        '{32'h0000_8000, 32'h400C_0010, 2'd1, 3'd2, 1'b0, 8'd5},  // R5 sys hits r2
        '{32'h0000_8000, 32'h0000_2000, 2'd1, 3'd2, 1'b1, 8'd5},  // R5 sys not on r0
        '{32'h0000_8000, 32'h2000_0010, 2'd2, 3'd2, 1'b0, 8'd5},  // R5 sys write r1
        '{32'h0000_1800, 32'h2000_0010, 2'd1, 3'd2, 1'b0, 8'd5},  // R5 pc ignored
        '{32'h0000_8000, 32'h0000_2000, 2'd1, 3'd3, 1'b0, 8'd6},  // R6 master r0
        '{32'h0000_8000, 32'h400C_0100, 2'd2, 3'd5, 1'b0, 8'd6},  // R6 master write r2
        '{32'h0000_8000, 32'h4010_0000, 2'd1, 3'd4, 1'b1, 8'd7},  // R7 r3 oversize
        '{32'h2000_0080, 32'h2000_0800, 2'd2, 3'd0, 1'b1, 8'd10}, // R10 trusted sram write
        '{32'h2000_0100, 32'h2000_0800, 2'd3, 3'd0, 1'b0, 8'd1},  // R1 pc past window end
        '{32'h0000_1FFF, 32'h0000_3FFF, 2'd1, 3'd0, 1'b1, 8'd1},  // R1 pc on window end
        '{32'h0000_8000, 32'h0000_3FFF, 2'd1, 3'd0, 1'b0, 8'd2},  // R2 addr on region end
        '{32'h0000_8000, 32'h0000_4000, 2'd2, 3'd0, 1'b1, 8'd2},  // R2 just past end
        '{32'h0000_8000, 32'h0000_2000, 2'd1, 3'd1, 1'b1, 8'd4}   // R4 instr bus read
    };

    task automatic load_cfg(input logic r0_en);
        cfg_pc_start = {32'h2000_0000, 32'h0000_1000};
        cfg_pc_end   = {32'h2000_00FF, 32'h0000_1FFF};
        cfg_pc_en    = 2'b11;
        cfg_rg_start = {32'h4010_0000, 32'h400C_0000, 32'h2000_0000, 32'h0000_1000};
        cfg_rg_end   = {32'h4080_0000, 32'h400C_FFFF, 32'h2000_0FFF, 32'h0000_3FFF};
        cfg_rg_en    = {3'b111, r0_en};
    endtask

    task automatic check(input bit ok, input string tag, input string act, input string exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%s expected=%s", tag, act, exp);
        end
    endtask

    // Drive at negedge, verdict registered at next posedge, sample at next negedge.
    task automatic apply(input vec_t v, input string tag);
        logic ew, er;
        logic [DW-1:0] ed;
        @(negedge clk);
        req_valid = 1'b1; req_pc = v.pc; req_addr = v.addr;
        req_kind = v.kind; req_src = v.src;
        @(negedge clk);
        req_valid = 1'b0;
        ew = v.exp && (v.kind == 2'd2);
        er = v.exp && (v.kind == 2'd1 || v.kind == 2'd3);
        ed = er ? MEMPAT : '0;
        check(grant == v.exp && viol == !v.exp && wr_en == ew && rd_data_out == ed, tag,
              $sformatf("g%0b v%0b w%0b d%h", grant, viol, wr_en, rd_data_out),
              $sformatf("g%0b v%0b w%0b d%h", v.exp, !v.exp, ew, ed));
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #400000;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        load_cfg(1'b1);
        repeat (3) @(negedge clk);
        // R11 reset state
        check(!grant && !viol && !wr_en && rd_data_out == '0, "R11 reset",
              $sformatf("%0b%0b%0b", grant, viol, wr_en), "000");
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++)
            apply(VEC[i], $sformatf("R%0d vec%0d", VEC[i].req, i));

        // R9 violation lasts one cycle; R11 idle after it
        apply(VEC[0], "R9 deny");
        @(negedge clk);
        check(!viol && !grant && !wr_en, "R11 idle after deny",
              $sformatf("g%0b v%0b", grant, viol), "g0 v0");

        // R8 config change after release is ignored
        load_cfg(1'b0);
        apply(VEC[0], "R8 cfg ignored after reset");

        // R8 new reset captures disabled region 0; R2 disabled never matches
        do_reset();
        apply('{32'h0000_8000, 32'h0000_2000, 2'd1, 3'd0, 1'b1, 8'd2}, "R8 R2 relatch disabled");
        apply('{32'h0000_8000, 32'h0000_2000, 2'd2, 3'd3, 1'b1, 8'd2}, "R2 disabled master");

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule